// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the full-width unsigned product of two operands by repeated conditional addition and right shifting, one multiplier bit per clock. A multiplicand register, a carry-producing adder and a double-width product register make up the datapath. The multiplier operand is not stored separately: it sits in the low half of the product register and is consumed bit by bit as the partial product grows into the upper half.

A small controller steers the datapath. Its only input from the datapath is the lowest bit of the product register. From that bit it issues an add strobe, a shift strobe and a product write strobe, plus a load strobe. Holding the synchronous reset high loads both operands on every clock. Releasing reset starts the multiply, which finishes after exactly one clock per multiplier bit. The done flag then rises, and the result stays frozen until reset is raised again.

Top module: `shiftadd_mul`

## Requirements
- R1: While `rst` is high, each rising clock edge stores `mcand_i` and sets `product_o` to the multiplier operand zero-extended, so that bits [31:0] are `mplier_i` and bits [63:32] are 0. During reset `done_o` is 0.
- R2: After `rst` falls, `done_o` stays 0 through the first 31 rising edges and reads 1 after the 32nd.
- R3: When `done_o` is 1, `product_o` equals the full 64-bit unsigned product of the two operands captured during reset.
- R4: The carry out of each upper-half addition is kept. An all-ones by all-ones multiply gives 0xFFFFFFFE00000001.
- R5: Once `done_o` is 1, it stays 1 and `product_o` does not change until `rst` is raised again.
- R6: Changes on `mcand_i` and `mplier_i` while `rst` is low do not affect the result.
- R7: Raising `rst` during a multiply abandons it. `done_o` clears, the new operands load, and a full 32-step multiply follows the next release.
- R8: A zero operand on either side gives a zero product. A multiplier of 1 returns the multiplicand, and a multiplicand of 1 returns the multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also the operand load command |
| mcand_i | input | 32 | Multiplicand operand |
| mplier_i | input | 32 | Multiplier operand |
| product_o | output | 64 | Product register contents |
| done_o | output | 1 | High once the 32 steps are complete |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the product register always holds a defined loaded value before any step runs. They also assume that a multiply is only judged after a reset pulse of at least one edge. The bench drives `rst` high from time zero and gives every scenario a reset pulse. It changes operands and reset only on falling clock edges, so every load and release lands on a clean rising edge.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {S_RUN = 1'b0, S_DONE = 1'b1} mul_state_t;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  always_comb {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/mul_mcand_reg.sv
module mul_mcand_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mul_prod_reg.sv
module mul_prod_reg #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           load_i,
  input  logic           wen_i,
  input  logic           add_i,
  input  logic           shift_i,
  input  logic [W-1:0]   mplier_i,
  input  logic [W-1:0]   sum_i,
  input  logic           cout_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [W:0]    upper_ext;
  logic [PW:0]   full_ext;
  logic [PW-1:0] nxt;

  always_comb begin
    upper_ext = add_i ? {cout_i, sum_i} : {1'b0, prod_o[PW-1:W]};
    full_ext  = {upper_ext, prod_o[W-1:0]};
    nxt       = shift_i ? full_ext[PW:1] : full_ext[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (load_i)     prod_o <= {{W{1'b0}}, mplier_i};
    else if (wen_i) prod_o <= nxt;
  end

  // R1: a load leaves the zero-extended multiplier in the register
  a_r1_load_image: assert property (@(posedge clk)
    load_i |=> (prod_o == {{W{1'b0}}, $past(mplier_i)}));

  // R5: without a write strobe the product does not move
  a_r5_hold_product: assert property (@(posedge clk) disable iff (load_i)
    !wen_i |=> $stable(prod_o));

  // R4: a shift with no add pulls a zero into the top bit
  a_r4_no_add_top_zero: assert property (@(posedge clk) disable iff (load_i)
    (wen_i && shift_i && !add_i) |=> !prod_o[PW-1]);
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic prod_lsb_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic wen_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_t    state;
  logic [CW-1:0] step;
  logic          running;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_RUN;
      step  <= '0;
    end else if (state == S_RUN) begin
      step <= step + 1'b1;
      if (step == LAST) state <= S_DONE;
    end
  end

  always_comb begin
    running = !rst && (state == S_RUN);
    load_o  = rst;
    wen_o   = running;
    shift_o = running;
    add_o   = running && prod_lsb_i;
    done_o  = (state == S_DONE);
  end

  // R5: done is sticky until reset
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R3: an add is only issued on a set product LSB within a write
  a_r3_add_qualified: assert property (@(posedge clk) disable iff (rst)
    add_o |-> (prod_lsb_i && wen_o && shift_o));

  // R7: a reset edge always clears the done flag
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> !done_o);
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);
  logic         load, add, shift, wen;
  logic [W-1:0] mcand_q, sum;
  logic         cout;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .prod_lsb_i(product_o[0]),
    .load_o(load), .add_o(add), .shift_o(shift), .wen_o(wen), .done_o(done_o)
  );

  mul_mcand_reg #(.W(W)) u_mcand (
    .clk(clk), .load_i(load), .d_i(mcand_i), .q_o(mcand_q)
  );

  mul_adder #(.W(W)) u_add (
    .a_i(product_o[2*W-1:W]), .b_i(mcand_q), .sum_o(sum), .cout_o(cout)
  );

  mul_prod_reg #(.W(W)) u_prod (
    .clk(clk), .load_i(load), .wen_i(wen), .add_i(add), .shift_i(shift),
    .mplier_i(mplier_i), .sum_i(sum), .cout_i(cout), .prod_o(product_o)
  );

  // R2: done never rises while reset holds
  a_r2_no_done_in_reset: assert property (@(posedge clk)
    rst |=> !done_o);
endmodule

// File: tb/tb_shiftadd_mul.sv
module tb_shiftadd_mul;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int n_run = 0;
  int n_fail = 0;
  int seed = 32'h1234_5678;

  shiftadd_mul #(.W(W)) dut (
    .clk(clk), .rst(rst), .mcand_i(mcand), .mplier_i(mplier),
    .product_o(product), .done_o(done)
  );

  always #2 clk = ~clk;

  task automatic check64(input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // load operands with one reset edge, then release; returns at a negedge
  task automatic start(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    rst = 1'b1; mcand = a; mplier = b;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [W-1:0] a,
                         input logic [W-1:0] b);
    logic [2*W-1:0] exp;
    exp = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    start(a, b);
    repeat (W) @(posedge clk);
    @(negedge clk);
    check1({req, " done"}, done, 1'b1);
    check64(req, product, exp);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1; mcand = 32'hDEAD_BEEF; mplier = 32'h0BAD_F00D;
    @(posedge clk);
    @(negedge clk);
    check64("R1 load image", product, {32'h0, 32'h0BAD_F00D});
    check1("R1 done low in reset", done, 1'b0);
  endtask

  task automatic t_timing();
    start(32'd7, 32'd9);
    repeat (W - 1) @(posedge clk);
    @(negedge clk);
    check1("R2 done low after 31", done, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check1("R2 done high after 32", done, 1'b1);
    check64("R3 7*9", product, 64'd63);
  endtask

  task automatic t_corners();
    run_one("R8 zero mcand", 32'h0, 32'hFFFF_FFFF);
    run_one("R8 zero mplier", 32'h1234_5678, 32'h0);
    run_one("R8 mplier one", 32'h8765_4321, 32'h1);
    run_one("R8 mcand one", 32'h1, 32'hCAFE_BABE);
    run_one("R4 all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check64("R4 exact value", product, 64'hFFFF_FFFE_0000_0001);
    run_one("R4 top bits", 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_random();
    for (int i = 0; i < 100; i++) begin
      logic [W-1:0] a, b;
      a = $random(seed);
      b = $random(seed);
      run_one($sformatf("R3 random #%0d", i), a, b);
    end
  endtask

  task automatic t_ignore_inputs();
    start(32'h0001_0003, 32'h0000_FFFF);
    repeat (5) @(posedge clk);
    @(negedge clk);
    mcand = 32'hFFFF_FFFF; mplier = 32'hAAAA_AAAA;
    repeat (W - 5) @(posedge clk);
    @(negedge clk);
    check64("R6 inputs ignored", product, 64'h0001_0003 * 64'h0000_FFFF);
  endtask

  task automatic t_hold();
    logic [2*W-1:0] exp;
    exp = 64'h0000_1234 * 64'h0000_5678;
    run_one("R5 base", 32'h1234, 32'h5678);
    mcand = 32'h5555_5555; mplier = 32'h3333_3333;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check1("R5 done held", done, 1'b1);
    check64("R5 product held", product, exp);
  endtask

  task automatic t_restart();
    start(32'hFFFF_0000, 32'h0F0F_0F0F);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 1'b1; mcand = 32'd1000; mplier = 32'd3000;
    @(posedge clk);
    @(negedge clk);
    check1("R7 done cleared", done, 1'b0);
    check64("R7 reload", product, 64'd3000);
    rst = 1'b0;
    repeat (W) @(posedge clk);
    @(negedge clk);
    check1("R7 done after restart", done, 1'b1);
    check64("R7 restarted result", product, 64'd3_000_000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    t_timing();
    t_corners();
    t_random();
    t_ignore_inputs();
    t_hold();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule